// File: doc/BRIEF.md
# Conditional Skip Microinstruction Unit

This unit executes the second group of operate microinstructions for a 12-bit accumulator machine. The sequencer presents an instruction word with a one-cycle strobe, along with the current accumulator, the link flag and the front-panel switch value. One cycle later the unit returns three results. The first is a request to skip the next instruction. The second is the updated accumulator value for write-back. The third is a request to halt.

Within one word, each action sits on its own bit. The three skip conditions are all measured against the accumulator as it was on entry. After the skip decision comes the clear. The switch merge and the halt request act last. Selected conditions are combined by OR. When the sense-reversal bit is set, the unit instead takes the AND of their negations. A word outside the second group, or one with its lowest bit set, is refused: the unit raises an error flag and takes no other action.

The program counter update, the processor's stop sequencing and third-group words are handled elsewhere.

Top module: `skip_group_unit`

## Requirements
- R1: A word is accepted only when bits 11:8 are all ones and bit 0 is zero. Any other word yields bad_word=1, skip_req=0 and halt_req=0, and acc_out equals acc_in unchanged.
- R2: With bit 3 clear, skip_req is the OR of the selected tests. Bit 6 selects "accumulator negative", meaning acc bit 11 is set. Bit 5 selects "accumulator zero". Bit 4 selects "link set".
- R3: With bit 3 set, skip_req is the AND of the negations of the selected tests. When no test is selected, the skip is unconditional.
- R4: With bit 3 clear and bits 6:4 all zero, skip_req is 0.
- R5: The skip tests use the accumulator value on entry. A clear in the same word (bit 7) does not change the skip outcome.
- R6: For an accepted word, acc_out is acc_in, or zero when bit 7 is set. That value is then ORed with the switches when bit 2 is set. Clear together with the switch merge therefore loads the switches exactly.
- R7: For an accepted word, halt_req equals bit 1.
- R8: out_valid rises exactly one cycle after op_valid, and all results appear in that same cycle. In any cycle without a result, skip_req, halt_req and bad_word are 0, and acc_out holds its last value.
- R9: After synchronous reset, out_valid, skip_req, halt_req, bad_word and acc_out are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Strobe marking a word to execute |
| op_word | input | 12 | Instruction word |
| acc_in | input | 12 | Accumulator on entry |
| link_in | input | 1 | Link flag on entry |
| switches | input | 12 | Front-panel switch value |
| out_valid | output | 1 | Results valid this cycle |
| skip_req | output | 1 | Skip the next instruction |
| acc_out | output | 12 | New accumulator value |
| halt_req | output | 1 | Halt request |
| bad_word | output | 1 | Word refused |

## Verification
Every result is due in the cycle after the strobe: out_valid, skip_req, halt_req, bad_word and acc_out all land together. The bench drives inputs on the falling edge. At the next falling edge, it compares every output against what the behavioural model predicted from the previous cycle's inputs. The comparison therefore runs once per clock, whether or not a strobe was given, which also covers the idle-cycle rules of R8. The sweep covers all 256 low-byte codes of the group against four boundary accumulator values and both link states. Directed words cover clear-with-test and clear-with-merge, plus refused words.

// File: rtl/skip_pkg.sv
package skip_pkg;

    localparam int WORD_W   = 12;
    localparam int GROUP_HI = 11;
    localparam int GROUP_LO = 8;

    // Bit positions inside the word (index 0 = least significant)
    localparam int B_CLEAR   = 7;
    localparam int B_NEG     = 6;
    localparam int B_ZERO    = 5;
    localparam int B_LINK    = 4;
    localparam int B_REVERSE = 3;
    localparam int B_MERGE   = 2;
    localparam int B_HALT    = 1;
    localparam int B_RSVD    = 0;

    localparam int N_TESTS = 3;

    typedef struct packed {
        logic               accept;
        logic               clear;
        logic [N_TESTS-1:0] test_sel;   // {neg, zero, link}
        logic               reverse;
        logic               merge;
        logic               halt;
    } skip_ctl_t;

    function automatic skip_ctl_t decode_word(input logic [WORD_W-1:0] w);
        skip_ctl_t c;
        c.accept   = (w[GROUP_HI:GROUP_LO] == '1) && !w[B_RSVD];
        c.clear    = w[B_CLEAR];
        c.test_sel = {w[B_NEG], w[B_ZERO], w[B_LINK]};
        c.reverse  = w[B_REVERSE];
        c.merge    = w[B_MERGE];
        c.halt     = w[B_HALT];
        return c;
    endfunction

endpackage

// File: rtl/skip_decode.sv
module skip_decode
    import skip_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output skip_ctl_t         ctl
);
    always_comb ctl = decode_word(word);
endmodule

// File: rtl/skip_test.sv
module skip_test
    import skip_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  skip_ctl_t         ctl,
    input  logic [DATA_W-1:0] acc,
    input  logic              link,
    output logic              skip
);
    logic [N_TESTS-1:0] cond;
    logic [N_TESTS-1:0] hit;

    // Conditions measured on the entry accumulator
    assign cond = {acc[DATA_W-1], (acc == '0), link};

    for (genvar i = 0; i < N_TESTS; i++) begin : g_hit
        assign hit[i] = ctl.test_sel[i] & cond[i];
    end

    always_comb begin
        if (ctl.reverse) skip = ~|hit;
        else             skip = |hit;
    end
endmodule

// File: rtl/skip_acc_path.sv
module skip_acc_path
    import skip_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  skip_ctl_t         ctl,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] sw,
    output logic [DATA_W-1:0] acc_next
);
    logic [DATA_W-1:0] after_clear;

    always_comb begin
        after_clear = ctl.clear ? '0 : acc;
        acc_next    = ctl.merge ? (after_clear | sw) : after_clear;
    end
endmodule

// File: rtl/skip_group_unit.sv
module skip_group_unit
    import skip_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [WORD_W-1:0] op_word,
    input  logic [DATA_W-1:0] acc_in,
    input  logic              link_in,
    input  logic [DATA_W-1:0] switches,
    output logic              out_valid,
    output logic              skip_req,
    output logic [DATA_W-1:0] acc_out,
    output logic              halt_req,
    output logic              bad_word
);
    skip_ctl_t         ctl;
    logic              skip_c;
    logic [DATA_W-1:0] acc_c;

    skip_decode u_dec (.word(op_word), .ctl(ctl));

    skip_test #(.DATA_W(DATA_W)) u_test (
        .ctl(ctl), .acc(acc_in), .link(link_in), .skip(skip_c)
    );

    skip_acc_path #(.DATA_W(DATA_W)) u_acc (
        .ctl(ctl), .acc(acc_in), .sw(switches), .acc_next(acc_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            skip_req  <= 1'b0;
            halt_req  <= 1'b0;
            bad_word  <= 1'b0;
            acc_out   <= '0;
        end else begin
            out_valid <= op_valid;
            if (op_valid) begin
                bad_word <= !ctl.accept;
                skip_req <= ctl.accept && skip_c;
                halt_req <= ctl.accept && ctl.halt;
                acc_out  <= ctl.accept ? acc_c : acc_in;
            end else begin
                bad_word <= 1'b0;
                skip_req <= 1'b0;
                halt_req <= 1'b0;
            end
        end
    end

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> out_valid); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(skip_req || halt_req || bad_word)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(acc_out)); // R8
    AST_REJECT_NO_ACTION: assert property (@(posedge clk) disable iff (rst)
        bad_word |-> !skip_req && !halt_req); // R1
    AST_REJECT_ACC_KEPT: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_word[0] |=> bad_word && acc_out == $past(acc_in)); // R1
    AST_CLEAR_MERGE_LOAD: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_word == 12'o7604 |=> acc_out == $past(switches)); // R6
    AST_PLAIN_NEVER_SKIPS: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_word[6:3] == 4'b0000 |=> !skip_req); // R4
    AST_REVERSE_EMPTY_SKIPS: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_word[11:8] == 4'hF && !op_word[0] && op_word[6:3] == 4'b0001
        |=> skip_req); // R3
    AST_HALT_MATCHES: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_word[11:8] == 4'hF && !op_word[0] |=> halt_req == $past(op_word[1])); // R7

endmodule

// File: tb/tb_skip_group_unit.sv
`timescale 1ns/1ps
module tb_skip_group_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [11:0] op_word = '0;
    logic [11:0] acc_in = '0;
    logic        link_in = 1'b0;
    logic [11:0] switches = '0;
    logic        out_valid, skip_req, halt_req, bad_word;
    logic [11:0] acc_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // expected outputs for the next compare point
    bit   e_valid = 0, e_skip = 0, e_halt = 0, e_bad = 0;
    int   e_acc = 0;
    string tag_skip = "R9", tag_acc = "R9", tag_flag = "R9";

    always #10 clk = ~clk;   // 50 MHz

    skip_group_unit dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word),
        .acc_in(acc_in), .link_in(link_in), .switches(switches),
        .out_valid(out_valid), .skip_req(skip_req), .acc_out(acc_out),
        .halt_req(halt_req), .bad_word(bad_word)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0o expected=%0o", tag, what, got, exp);
        end
    endtask

    task automatic compare_all();
        check("R8", "out_valid", out_valid, e_valid);
        check(tag_skip, "skip_req", skip_req, e_skip);
        check(tag_flag, "halt_req", halt_req, e_halt);
        check(tag_flag, "bad_word", bad_word, e_bad);
        check(tag_acc, "acc_out", acc_out, e_acc);
    endtask

    // behavioural model, fills the expectation for the next cycle
    task automatic model(input bit v, input int w, input int a, input bit l, input int s);
        bit ok, neg, zer, sn, sz, sl, rev, anyhit;
        int res;
        e_valid = v;
        if (!v) begin
            e_skip = 0; e_halt = 0; e_bad = 0;
            tag_skip = "R8"; tag_flag = "R8"; tag_acc = "R8";
            return;
        end
        ok  = ((w >> 8) == 15) && ((w % 2) == 0);
        if (!ok) begin
            e_bad = 1; e_skip = 0; e_halt = 0; e_acc = a;
            tag_skip = "R1"; tag_flag = "R1"; tag_acc = "R1";
            return;
        end
        neg = (a >= 2048);
        zer = (a == 0);
        sn  = (w >> 6) % 2 == 1;
        sz  = (w >> 5) % 2 == 1;
        sl  = (w >> 4) % 2 == 1;
        rev = (w >> 3) % 2 == 1;
        anyhit = (sn && neg) || (sz && zer) || (sl && l);
        if (rev) begin
            e_skip = !anyhit; tag_skip = "R3";
        end else if (!sn && !sz && !sl) begin
            e_skip = 0; tag_skip = "R4";
        end else begin
            e_skip = anyhit; tag_skip = "R2";
        end
        res = ((w >> 7) % 2 == 1) ? 0 : a;
        if ((w >> 2) % 2 == 1) res = res | s;
        e_acc = res; tag_acc = "R6";
        e_halt = (w >> 1) % 2 == 1; tag_flag = "R7";
        e_bad = 0;
    endtask

    task automatic step(input bit v, input int w, input int a, input bit l, input int s);
        @(negedge clk);
        compare_all();
        op_valid = v; op_word = 12'(w); acc_in = 12'(a); link_in = l; switches = 12'(s);
        model(v, w, a, l, s);
    endtask

    initial begin
        int accs[4] = '{0, 'o4000, 'o7777, 1};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R9: reset state
        check("R9", "out_valid", out_valid, 0);
        check("R9", "skip_req", skip_req, 0);
        check("R9", "halt_req", halt_req, 0);
        check("R9", "bad_word", bad_word, 0);
        check("R9", "acc_out", acc_out, 0);

        // full group sweep
        for (int ai = 0; ai < 4; ai++) begin
            for (int l = 0; l < 2; l++) begin
                for (int c = 0; c < 256; c++) begin
                    step(1, 'o7400 | c, accs[ai], l[0], ('o1234 ^ (c * 5)) & 'o7777);
                    if (c % 9 == 0) step(0, 0, 0, 0, 0);
                end
            end
        end

        // R5: clear does not change the zero test (entry acc nonzero / zero)
        step(1, 'o7640, 5, 0, 0);
        @(negedge clk);
        check("R5", "skip with clear, acc=5", skip_req, 0);
        check("R5", "acc cleared", acc_out, 0);
        op_valid = 0; model(0, 0, 0, 0, 0);
        step(1, 'o7640, 0, 0, 0);
        @(negedge clk);
        check("R5", "skip with clear, acc=0", skip_req, 1);
        op_valid = 0; model(0, 0, 0, 0, 0);
        step(1, 'o7700, 'o4000, 0, 0);   // clear + negative test
        @(negedge clk);
        check("R5", "neg test before clear", skip_req, 1);
        op_valid = 0; model(0, 0, 0, 0, 0);

        // R6: clear + merge loads switches exactly
        step(1, 'o7604, 'o7777, 1, 'o0505);
        @(negedge clk);
        check("R6", "clear+merge", acc_out, 'o0505);
        op_valid = 0; model(0, 0, 0, 0, 0);

        // R1: refused words
        step(1, 'o7000, 'o1111, 1, 'o7777);
        step(1, 'o6123, 'o2222, 0, 'o7777);
        step(1, 'o7403, 'o3333, 1, 'o7777);
        step(1, 'o7601, 'o0000, 0, 'o7777);
        step(1, 'o0000, 'o4444, 0, 0);
        // R8: idle cycles hold acc_out
        step(0, 'o7777, 'o1, 1, 'o7777);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        @(negedge clk);
        compare_all();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule